// File: doc/BRIEF.md
# Thermostat Alert With Consecutive-Fault Filter

This block turns a stream of temperature conversion results into a single alert line. Each time the converter reports a new 12-bit two's-complement reading (0.0625 degrees per LSB), the block compares it with a high threshold and a low threshold. A fault only counts once it repeats on a programmable number of back-to-back conversions, so a single noisy sample does not trip the line. The gap between the two thresholds gives hysteresis.

Two behaviours can be selected. In level (comparator) mode the line follows the filtered temperature. It turns on after enough readings at or above the high threshold. It turns off after the same number of readings under the low threshold. In latched (interrupt) mode the line turns on after enough high faults and stays on until software reads any register or wins an alert-response exchange. The block then waits for enough low readings to fire again, and keeps alternating between the two directions. The active level of the line is selectable. A source bit reports which threshold caused the latest firing.

Entering shutdown clears the alert and the filter, but only on the cycle shutdown is first requested. A soft-reset strobe returns the block to its idle state.

Top module: `therm_alert`

## Requirements
- R1: After reset the alert output sits at its inactive level (high when `cfg_act_high`=0) and `alert_src` is 0.
- R2: Readings and thresholds compare as signed 12-bit values with bit 11 as the sign. A high fault is a reading greater than or equal to `lim_high`. A low fault is a reading strictly below `lim_low`.
- R3: `cfg_queue_sel` sets how many consecutive qualifying conversions are needed: 0 needs 1, 1 needs 2, 2 needs 4, 3 needs 6.
- R4: A conversion that does not meet the condition currently being counted returns the consecutive count to zero.
- R5: With `cfg_intr_mode`=0 the alert turns on after the queued number of high faults. It turns off only after the same number of consecutive low faults. `reg_rd` and `ar_won` have no effect.
- R6: With `cfg_intr_mode`=1 the alert turns on after the queued high faults and holds until `reg_rd` or `ar_won`. It then fires only on queued low faults, is again held until cleared, and then counts high faults again.
- R7: `cfg_act_high`=0 drives the active alert as 0. `cfg_act_high`=1 drives it as 1.
- R8: `alert_src` becomes 1 when the alert fires on the high threshold and 0 when it fires on the low threshold. It keeps that value until the next firing.
- R9: A 0-to-1 change of `cfg_shutdown` clears the alert and the fault count in both modes. Holding `cfg_shutdown` at 1 clears nothing more.
- R10: `soft_rst` clears the alert, the fault count and `alert_src`, and makes the block count high faults next.
- R11: All outputs are registered state. A conversion sampled on one clock edge is reflected on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a new reading is on `conv_result` |
| conv_result | input | 12 | Signed temperature reading, 0.0625 degrees/LSB |
| lim_high | input | 12 | Signed high threshold |
| lim_low | input | 12 | Signed low threshold |
| cfg_intr_mode | input | 1 | 0 = level mode, 1 = latched mode |
| cfg_act_high | input | 1 | Alert active level: 0 low, 1 high |
| cfg_queue_sel | input | 2 | Consecutive-fault depth select |
| cfg_shutdown | input | 1 | Shutdown request; its rising edge clears the alert |
| reg_rd | input | 1 | Strobe: a register read took place |
| ar_won | input | 1 | Strobe: this block won an alert-response exchange |
| soft_rst | input | 1 | Strobe: soft reset |
| alert_pin | output | 1 | Alert level after polarity |
| alert_src | output | 1 | 1 = last firing from high threshold, 0 = from low |

## Verification
A corrupted fault count shows up as an alert that fires one or more conversions early or late. It becomes visible on `alert_pin` right after the conversion where the queued depth should or should not have been reached. A wrong arming direction in latched mode stays hidden until the next reading that falls on the wrong side of a threshold, so the bench feeds readings that should not fire after every clear. Wrong signed comparison only appears with negative thresholds or readings, and is checked by crossing zero. A stale `alert_src` is checked right after each firing and after each level-mode release.

// File: rtl/therm_pkg.sv
package therm_pkg;

  parameter int TEMP_W = 12;
  parameter int QCNT_W = 3;

  typedef enum logic [1:0] {
    ST_WATCH_HI = 2'd0,
    ST_FIRED_HI = 2'd1,
    ST_WATCH_LO = 2'd2,
    ST_FIRED_LO = 2'd3
  } alert_st_t;

  // Number of consecutive qualifying conversions for each select code.
  function automatic logic [QCNT_W-1:0] fq_depth(input logic [1:0] sel);
    case (sel)
      2'd0:    fq_depth = QCNT_W'(1);
      2'd1:    fq_depth = QCNT_W'(2);
      2'd2:    fq_depth = QCNT_W'(4);
      default: fq_depth = QCNT_W'(6);
    endcase
  endfunction

  // Signed "a >= b" over the reading width.
  function automatic logic at_or_above(input logic [TEMP_W-1:0] a,
                                       input logic [TEMP_W-1:0] b);
    at_or_above = ($signed(a) >= $signed(b));
  endfunction

  // Signed "a < b" over the reading width.
  function automatic logic strictly_below(input logic [TEMP_W-1:0] a,
                                          input logic [TEMP_W-1:0] b);
    strictly_below = ($signed(a) < $signed(b));
  endfunction

endpackage

// File: rtl/therm_limit_cmp.sv
module therm_limit_cmp
  import therm_pkg::*;
#(
  parameter int TW = TEMP_W
) (
  input  logic [TW-1:0] reading,
  input  logic [TW-1:0] thr_high,
  input  logic [TW-1:0] thr_low,
  output logic          over_high,
  output logic          under_low
);

  assign over_high = at_or_above(reading, thr_high);
  assign under_low = strictly_below(reading, thr_low);

endmodule

// File: rtl/therm_fault_queue.sv
module therm_fault_queue
  import therm_pkg::*;
#(
  parameter int CW = QCNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          count_en,
  input  logic          hit,
  input  logic [CW-1:0] depth,
  output logic          fire,
  output logic [CW-1:0] run_len
);

  localparam int EW = CW + 1;

  logic [EW-1:0] next_len;

  assign next_len = {1'b0, run_len} + EW'(1);
  assign fire     = count_en && hit && (next_len >= {1'b0, depth});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (flush) begin
      run_len <= '0;
    end else if (count_en) begin
      if (hit && !fire) run_len <= next_len[CW-1:0];
      else              run_len <= '0;
    end
  end

  // R4: a counted conversion that misses leaves the run at zero
  a_r4_miss_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !hit) |=> (run_len == '0));

  // R3: the run never reaches the deepest queue setting
  a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_len < CW'(6));

  // R3: a firing always restarts the run
  a_r3_fire_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (run_len == '0));

endmodule

// File: rtl/therm_alert_ctrl.sv
module therm_alert_ctrl
  import therm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic intr_mode,
  input  logic conv_done,
  input  logic over_high,
  input  logic under_low,
  input  logic fire,
  input  logic ack_clear,
  input  logic sd_rise,
  input  logic soft_rst,
  output logic count_en,
  output logic count_hit,
  output logic flush,
  output logic active,
  output logic src_high
);

  alert_st_t state, state_nx;
  logic      src_nx;
  logic      watch_low;
  logic      fired_st;
  logic      assert_ev;

  assign fired_st  = (state == ST_FIRED_HI) || (state == ST_FIRED_LO);
  assign active    = fired_st;
  assign watch_low = intr_mode ? (state == ST_WATCH_LO) : fired_st;
  assign count_en  = conv_done && (intr_mode ? !fired_st : 1'b1);
  assign count_hit = watch_low ? under_low : over_high;
  assign flush     = soft_rst || sd_rise;
  assign assert_ev = fire && !fired_st;

  always_comb begin
    state_nx = state;
    src_nx   = src_high;
    if (soft_rst) begin
      state_nx = ST_WATCH_HI;
      src_nx   = 1'b0;
    end else if (sd_rise) begin
      state_nx = ST_WATCH_HI;
    end else if (!intr_mode) begin
      if (fire) begin
        if (fired_st) begin
          state_nx = ST_WATCH_HI;
        end else begin
          state_nx = ST_FIRED_HI;
          src_nx   = 1'b1;
        end
      end
    end else begin
      case (state)
        ST_WATCH_HI: if (fire) begin
          state_nx = ST_FIRED_HI;
          src_nx   = 1'b1;
        end
        ST_FIRED_HI: if (ack_clear) state_nx = ST_WATCH_LO;
        ST_WATCH_LO: if (fire) begin
          state_nx = ST_FIRED_LO;
          src_nx   = 1'b0;
        end
        default:     if (ack_clear) state_nx = ST_WATCH_HI;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_WATCH_HI;
      src_high <= 1'b0;
    end else begin
      state    <= state_nx;
      src_high <= src_nx;
    end
  end

  // R6: in latched mode the alert holds until an acknowledge or clear
  a_r6_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_mode && active && !ack_clear && !sd_rise && !soft_rst) |=> active);

  // R5: in level mode the alert only moves on a conversion or a clear
  a_r5_level_moves_on_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (!intr_mode && !conv_done && !sd_rise && !soft_rst) |=> $stable(active));

  // R8: the source bit changes only on a firing or soft reset
  a_r8_src_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_high) |-> $past(assert_ev || soft_rst));

  // R10: soft reset leaves the alert off and the source cleared
  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!active && !src_high));

endmodule

// File: rtl/therm_alert.sv
module therm_alert
  import therm_pkg::*;
#(
  parameter int TW = TEMP_W,
  parameter int CW = QCNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [TW-1:0] conv_result,
  input  logic [TW-1:0] lim_high,
  input  logic [TW-1:0] lim_low,
  input  logic          cfg_intr_mode,
  input  logic          cfg_act_high,
  input  logic [1:0]    cfg_queue_sel,
  input  logic          cfg_shutdown,
  input  logic          reg_rd,
  input  logic          ar_won,
  input  logic          soft_rst,
  output logic          alert_pin,
  output logic          alert_src
);

  logic          over_high, under_low;
  logic          count_en, count_hit, flush, fire;
  logic          alert_active;
  logic          sd_q, sd_rise;
  logic [CW-1:0] depth, run_len;

  assign depth   = fq_depth(cfg_queue_sel);
  assign sd_rise = cfg_shutdown && !sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else        sd_q <= cfg_shutdown;
  end

  therm_limit_cmp #(.TW(TW)) u_cmp (
    .reading   (conv_result),
    .thr_high  (lim_high),
    .thr_low   (lim_low),
    .over_high (over_high),
    .under_low (under_low)
  );

  therm_fault_queue #(.CW(CW)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .count_en (count_en),
    .hit      (count_hit),
    .depth    (depth),
    .fire     (fire),
    .run_len  (run_len)
  );

  therm_alert_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .intr_mode (cfg_intr_mode),
    .conv_done (conv_done),
    .over_high (over_high),
    .under_low (under_low),
    .fire      (fire),
    .ack_clear (reg_rd || ar_won),
    .sd_rise   (sd_rise),
    .soft_rst  (soft_rst),
    .count_en  (count_en),
    .count_hit (count_hit),
    .flush     (flush),
    .active    (alert_active),
    .src_high  (alert_src)
  );

  assign alert_pin = cfg_act_high ? alert_active : !alert_active;

  // R9: a rising shutdown request clears the alert and the run
  a_r9_sd_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_shutdown && !sd_q) |=> (!alert_active && run_len == '0));

  // R11: the alert never turns on without a conversion in the prior cycle
  a_r11_on_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_active) |-> $past(conv_done));

endmodule

// File: tb/therm_alert_bench.sv
module therm_alert_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_result = '0;
  logic [11:0] lim_high = 12'h320;
  logic [11:0] lim_low = 12'h190;
  logic        cfg_intr_mode = 1'b0;
  logic        cfg_act_high = 1'b0;
  logic [1:0]  cfg_queue_sel = 2'd0;
  logic        cfg_shutdown = 1'b0;
  logic        reg_rd = 1'b0;
  logic        ar_won = 1'b0;
  logic        soft_rst = 1'b0;
  logic        alert_pin, alert_src;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  therm_alert u_therm_alert (
    .clk, .rst_n, .conv_done, .conv_result, .lim_high, .lim_low,
    .cfg_intr_mode, .cfg_act_high, .cfg_queue_sel, .cfg_shutdown,
    .reg_rd, .ar_won, .soft_rst, .alert_pin, .alert_src
  );

  task automatic check(input logic exp_act, input logic exp_src, input string tag);
    logic exp_pin;
    exp_pin = cfg_act_high ? exp_act : ~exp_act;
    compared++;
    if (alert_pin !== exp_pin || alert_src !== exp_src) begin
      mismatched++;
      $display("FAIL %s: pin=%b src=%b expected pin=%b src=%b",
               tag, alert_pin, alert_src, exp_pin, exp_src);
    end
  endtask

  task automatic conv(input logic [11:0] t);
    @(negedge clk); conv_result = t; conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse_won();
    @(negedge clk); ar_won = 1'b1;
    @(negedge clk); ar_won = 1'b0;
  endtask

  task automatic do_soft_rst();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic t_reset();
    check(1'b0, 1'b0, "R1 reset state");
  endtask

  task automatic t_compare();
    do_soft_rst(); cfg_intr_mode = 0; cfg_queue_sel = 0;
    lim_high = 12'h320; lim_low = 12'h190;
    conv(12'h31F); check(0, 0, "R2 one below high");
    conv(12'h320); check(1, 1, "R2 equal to high fires");
    conv(12'h190); check(1, 1, "R2 equal to low is not below");
    conv(12'h18F); check(0, 1, "R2 R5 below low releases, R8 src held");
    lim_high = 12'hFFC; lim_low = 12'hE70;
    conv(12'h7FF); check(1, 1, "R2 signed: positive above negative high");
    conv(12'hE70); check(1, 1, "R2 signed: equal negative low holds");
    conv(12'hC90); check(0, 1, "R2 signed: -55 below -25 releases");
    lim_high = 12'h320; lim_low = 12'h190;
  endtask

  task automatic t_queue();
    do_soft_rst(); cfg_intr_mode = 0;
    cfg_queue_sel = 2'd1;
    conv(12'h400); conv(12'h200); conv(12'h400);
    check(0, 0, "R4 miss restarts depth-2 run");
    conv(12'h400); check(1, 1, "R3 depth 2 fires on 2nd");
    do_soft_rst(); cfg_queue_sel = 2'd2;
    for (int i = 0; i < 3; i++) conv(12'h400);
    check(0, 0, "R3 depth 4 silent after 3");
    conv(12'h400); check(1, 1, "R3 depth 4 fires on 4th");
    cfg_queue_sel = 2'd3;
    for (int i = 0; i < 5; i++) conv(12'h100);
    conv(12'h200);
    for (int i = 0; i < 5; i++) conv(12'h100);
    check(1, 1, "R4 miss restarts depth-6 release run");
    conv(12'h100); check(0, 1, "R3 R5 depth 6 releases on 6th low");
    cfg_queue_sel = 2'd0;
  endtask

  task automatic t_level_ignores();
    do_soft_rst(); cfg_intr_mode = 0;
    conv(12'h400); pulse_rd(); pulse_won();
    check(1, 1, "R5 reads and wins ignored in level mode");
  endtask

  task automatic t_latched();
    do_soft_rst(); cfg_intr_mode = 1;
    conv(12'h400); check(1, 1, "R6 fires on high");
    conv(12'h100); check(1, 1, "R6 holds across low reading");
    pulse_rd(); check(0, 1, "R6 read clears");
    conv(12'h400); check(0, 1, "R6 armed low ignores high");
    conv(12'h100); check(1, 0, "R6 R8 fires on low, src 0");
    pulse_won(); check(0, 0, "R6 won response clears");
    conv(12'h100); check(0, 0, "R6 armed high ignores low");
    conv(12'h400); check(1, 1, "R6 R8 fires on high again");
    cfg_act_high = 1; #1 check(1, 1, "R7 active-high level");
    pulse_rd(); check(0, 1, "R7 inactive with active-high");
    cfg_act_high = 0;
  endtask

  task automatic t_shutdown();
    do_soft_rst(); cfg_intr_mode = 0;
    conv(12'h400); check(1, 1, "R9 setup alert on");
    @(negedge clk); cfg_shutdown = 1'b1;
    @(negedge clk); check(0, 1, "R9 rising shutdown clears");
    conv(12'h400); @(negedge clk);
    check(1, 1, "R9 held shutdown does not clear");
    @(negedge clk); cfg_shutdown = 1'b0;
    @(negedge clk); cfg_shutdown = 1'b1;
    @(negedge clk); check(0, 1, "R9 new rising edge clears");
    cfg_shutdown = 1'b0;
  endtask

  task automatic t_soft();
    do_soft_rst(); cfg_intr_mode = 1;
    conv(12'h400); pulse_rd();
    do_soft_rst(); check(0, 0, "R10 soft reset clears src");
    conv(12'h100); check(0, 0, "R10 back to watching high");
    conv(12'h400); check(1, 1, "R10 fires on high after reset");
    cfg_intr_mode = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_compare();
    t_queue();
    t_level_ignores();
    t_latched();
    t_shutdown();
    t_soft();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule